// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

This block gathers five interrupt sources: two timer/input controllers, a network controller, a two-line serial controller and a non-maskable source. It turns them into a single 3-bit priority level for the CPU. A routing-mode input chooses between two source-to-level tables. A pending register keeps one bit per level, and the CPU sees the highest pending level. In classic routing the network request bypasses the CPU levels. It is sent out on a separate line that feeds an expansion-slot interrupt input of the second controller.

A one-cycle kick input starts a non-maskable request that is held for a fixed number of clock cycles and then released on its own. It acts like a debugger-injected NMI. The mode is sampled into a register that reset sets to alternate routing. Each source records the level it was routed to when it asserted, so a mode change affects only requests that assert after it.

Top module: `irq_level_router`

## Requirements
- R1: With the registered mode at 1 (classic), a newly asserted source maps as follows: controller A to level 1, controller B to level 2, serial to level 4 and NMI to level 7.
- R2: With the registered mode at 0 (alternate), a newly asserted source maps as follows: controller A to level 6, controller B to level 2, network to level 3, serial to level 4 and NMI to level 7.
- R3: A network request that asserts under classic routing sets no pending bit. While it stays high, `slot_irq_o` is 1. In every other case `slot_irq_o` is 0.
- R4: `pending_o` bit (L-1) is 1 exactly while some source routed to level L is high, and bit 7 is always 0. A source seen at clock edge k updates `pending_o` at edge k.
- R5: `ipl_o` is one plus the index of the highest set bit of `pending_o`, or 0 when no bit is set.
- R6: The two serial request lines are ORed, so either one alone raises level 4.
- R7: A one-cycle `nmi_kick_i` at edge k holds the NMI source active from edge k+1 for HOLD_CYCLES edges. A kick during the hold restarts the count, and `nmi_irq_i` ORs with the held source.
- R8: Reset clears the pending bits and the slot line, cancels any NMI hold and sets the registered mode to 0. `mode_i` is registered on each edge and used from the next one.
- R9: A source that stays high keeps its level across mode changes until it deasserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Routing mode: 1 classic, 0 alternate |
| ctl_a_irq_i | input | 1 | Controller A request |
| ctl_b_irq_i | input | 1 | Controller B request |
| net_irq_i | input | 1 | Network controller request |
| ser_irq_i | input | 2 | Two serial channel requests |
| nmi_irq_i | input | 1 | Level NMI source |
| nmi_kick_i | input | 1 | Starts a timed NMI hold |
| ipl_o | output | 3 | Highest pending priority level |
| pending_o | output | 8 | Pending bits, bit L-1 for level L |
| slot_irq_o | output | 1 | Redirected network request for the slot input |

## Verification
The bench builds the router with HOLD_CYCLES set to 20 instead of the ten-million default. At 20 cycles, a whole NMI hold, a retrigger in the middle of the hold and a reset during the hold all fit into a few dozen cycles. Random source and mode toggling then runs through thousands of cycles. During that run, requests held across mode flips and the redirected network line occur many times next to the directed cases.

// File: rtl/irq_level_router.sv
module irq_level_router #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_i,
  input  logic       ctl_a_irq_i,
  input  logic       ctl_b_irq_i,
  input  logic       net_irq_i,
  input  logic [1:0] ser_irq_i,
  input  logic       nmi_irq_i,
  input  logic       nmi_kick_i,
  output logic [2:0] ipl_o,
  output logic [7:0] pending_o,
  output logic       slot_irq_o
);
  localparam int LVL_W = 3;
  localparam int NSRC  = 5;
  localparam int NPEND = 1 << LVL_W;
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam int NET   = 2;

  function automatic logic [LVL_W-1:0] route_of(input logic classic, input int idx);
    case (idx)
      0:       return classic ? LVL_W'(1) : LVL_W'(6);
      1:       return LVL_W'(2);
      2:       return classic ? LVL_W'(0) : LVL_W'(3);
      3:       return LVL_W'(4);
      default: return LVL_W'(7);
    endcase
  endfunction

  logic             mode_q;
  logic [NSRC-1:0]  src, active_q;
  logic [LVL_W-1:0] route_q [NSRC];
  logic [LVL_W-1:0] route_d [NSRC];
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_on;
  logic [NPEND-1:0] pend_q, pend_d;
  logic             slot_q;

  assign hold_on = hold_cnt != '0;
  assign src = {nmi_irq_i | hold_on, |ser_irq_i, net_irq_i, ctl_b_irq_i, ctl_a_irq_i};

  for (genvar i = 0; i < NSRC; i++) begin : g_route
    assign route_d[i] = active_q[i] ? route_q[i] : route_of(mode_q, i);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) route_q[i] <= '0;
      else        route_q[i] <= route_d[i];
  end

  always_comb begin
    pend_d = '0;
    for (int b = 1; b < NPEND; b++)
      for (int i = 0; i < NSRC; i++)
        if (src[i] && route_d[i] == LVL_W'(b)) pend_d[b-1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      active_q <= '0;
      pend_q   <= '0;
      slot_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      mode_q   <= mode_i;
      active_q <= src;
      pend_q   <= pend_d;
      slot_q   <= src[NET] && route_d[NET] == '0;
      if (nmi_kick_i)   hold_cnt <= CNT_W'(HOLD_CYCLES);
      else if (hold_on) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_comb begin
    ipl_o = '0;
    for (int b = 0; b < NPEND; b++)
      if (pend_q[b]) ipl_o = LVL_W'(b + 1);
  end

  assign pending_o  = pend_q;
  assign slot_irq_o = slot_q;

  assert_slot_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_irq_o |-> !pending_o[2]);
  assert_ipl_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_o != 0) |-> pending_o[ipl_o - 1]);
  assert_zero_ipl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == 0) |-> (ipl_o == 0));
  assert_top_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_o[7]);
  assert_serial_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_irq_i != 0) |=> pending_o[3]);
  assert_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_kick_i |=> ##1 pending_o[6]);
  assert_keep_alt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o[5] && ctl_a_irq_i) |=> pending_o[5]);
  assert_keep_cls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o[0] && ctl_a_irq_i) |=> pending_o[0]);
endmodule

// File: tb/sim_irq_level_router.sv
module sim_irq_level_router;
  localparam int H = 20;
  logic clk = 0, rst_n = 0;
  logic mode, ca, cb, net, nmi, kick;
  logic [1:0] ser;
  logic [2:0] ipl;
  logic [7:0] pend;
  logic slot;
  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R8";

  always #5 clk = ~clk;

  irq_level_router #(.HOLD_CYCLES(H)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ctl_a_irq_i(ca), .ctl_b_irq_i(cb),
    .net_irq_i(net), .ser_irq_i(ser), .nmi_irq_i(nmi), .nmi_kick_i(kick),
    .ipl_o(ipl), .pending_o(pend), .slot_irq_o(slot));

  logic m_mode, m_slot;
  logic [4:0] m_act;
  int m_route [5];
  int m_cnt;
  logic [7:0] m_pend;

  function automatic int lvl(input logic classic, input int i);
    case (i)
      0: return classic ? 1 : 6;
      1: return 2;
      2: return classic ? 0 : 3;
      3: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic logic [2:0] top(input logic [7:0] p);
    logic [2:0] r = 0;
    for (int b = 0; b < 8; b++) if (p[b]) r = 3'(b + 1);
    return r;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_slot = 0; m_act = 0; m_cnt = 0; m_pend = 0;
    for (int i = 0; i < 5; i++) m_route[i] = 0;
  endtask

  task automatic model_edge();
    logic [4:0] s;
    int nr [5];
    s = {nmi | (m_cnt != 0), |ser, net, cb, ca};
    m_pend = 0;
    for (int i = 0; i < 5; i++) begin
      nr[i] = m_act[i] ? m_route[i] : lvl(m_mode, i);
      if (s[i] && nr[i] != 0) m_pend[nr[i]-1] = 1;
    end
    m_slot = s[2] && nr[2] == 0;
    for (int i = 0; i < 5; i++) m_route[i] = nr[i];
    m_act = s;
    m_cnt = kick ? H : (m_cnt != 0 ? m_cnt - 1 : 0);
    m_mode = mode;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!rst_n) model_reset(); else model_edge();
    @(negedge clk);
    checks++;
    if ({ipl, pend, slot} !== {top(m_pend), m_pend, m_slot}) begin
      fails++;
      $display("FAIL %s ipl/pend/slot actual %0d/%b/%b expected %0d/%b/%b",
               tag, ipl, pend, slot, top(m_pend), m_pend, m_slot);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic idle();
    ca = 0; cb = 0; net = 0; ser = 0; nmi = 0; kick = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    mode = 1; idle(); model_reset();
    tag = "R8"; run(3);
    @(negedge clk) rst_n = 1;
    net = 1; run(2);                 // R8: mode register starts at 0, net lands on level 3
    net = 0; run(2);
    tag = "R1"; ca = 1; run(2); cb = 1; run(2); ser = 2'b01; run(2); nmi = 1; run(2);
    idle(); run(2);
    tag = "R3"; net = 1; run(3); cb = 1; run(2); idle(); run(2);
    tag = "R2"; mode = 0; run(2);
    ca = 1; run(2); net = 1; run(2); cb = 1; run(2); ser = 2'b10; run(2); nmi = 1; run(2);
    tag = "R5"; nmi = 0; run(1); ca = 0; run(1); ser = 0; run(1); net = 0; run(1); cb = 0; run(2);
    tag = "R6"; ser = 2'b01; run(2); ser = 2'b11; run(1); ser = 2'b10; run(2); ser = 0; run(2);
    tag = "R9"; ca = 1; run(2); mode = 1; run(3); cb = 1; run(2); ca = 0; run(2);
    ca = 1; run(2); mode = 0; run(3); ca = 0; cb = 0; run(2);
    net = 1; run(2); mode = 1; run(3); net = 0; run(2); net = 1; run(2); mode = 0; run(3); net = 0; run(2);
    tag = "R7"; kick = 1; run(1); kick = 0; run(H + 4);
    kick = 1; run(1); kick = 0; run(8); kick = 1; run(1); kick = 0; run(H + 4);
    kick = 1; run(1); kick = 0; nmi = 1; run(H + 3); nmi = 0; run(2);
    tag = "R8"; kick = 1; ca = 1; mode = 1; run(1); kick = 0; run(4);
    @(negedge clk) rst_n = 0; ca = 0; run(2);
    @(negedge clk) rst_n = 1; run(H + 4);
    tag = "R4";
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) ca = ~ca;
      if ($urandom_range(7) == 0) cb = ~cb;
      if ($urandom_range(6) == 0) net = ~net;
      if ($urandom_range(7) == 0) ser = 2'($urandom);
      if ($urandom_range(15) == 0) nmi = ~nmi;
      kick = ($urandom_range(60) == 0);
      if ($urandom_range(11) == 0) mode = ~mode;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule